// File: doc/BRIEF.md
# Dual-channel ADC serial readout controller

This block is the host side of a link to a dual simultaneous-sampling 14-bit converter that is driven by a chip select and a serial clock. A start request pulls the active-low chip select down, and the block then produces a fixed number of serial clock periods. The converter uses the first periods to convert, so the controller counts clock edges and ignores the data lines while that happens. It then shifts in both 14-bit results, MSB first. The results come either from two data lines in parallel or one after the other on a single line.

A data bit changes on a falling serial clock edge. The controller samples it in the cycle where it drives the next rising edge, so the bit has been stable for a full half period. When the last bit is in, both words are sign-extended to 16 bits and marked by a one-cycle valid strobe. The controller can also issue a calibration pulse of fixed width. After the pulse, and after every frame, it holds chip select high for a minimum spacing. All timing is counted in system clock cycles set by parameters.

Top module: `adc_dual_rd`

## Requirements
- R1: After reset and whenever idle: cs_no=1, sclk_o=1, cal_o=0, busy_o=0, res_valid_o=0.
- R2: While cs_no is low, sclk_o changes level every SCLK_HALF system clock cycles. It is high when cs_no falls, its first change is a falling edge, and it is high when cs_no rises.
- R3: A frame has exactly 33 falling sclk_o edges in dual-line mode (single_line_i=0) and 47 in single-line mode (single_line_i=1). cs_no rises together with the rising edge that follows the last falling edge.
- R4: The data lines are sampled in the clock cycle in which sclk_o is driven high. The levels present at the rising edges after falling edges 1 to 18 (the conversion interval) have no effect on any result.
- R5: Dual-line mode: at the rising edges after falling edges 19 to 32, bits 13 down to 0 of channel A are taken from sdata_a_i and, at the same edges, those of channel B from sdata_b_i.
- R6: Single-line mode: channel A is taken from sdata_a_i after falling edges 19 to 32, and channel B is taken from sdata_a_i after falling edges 33 to 46. sdata_b_i is ignored.
- R7: res_valid_o is high for exactly one cycle, one cycle after the rising sclk_o edge of the last captured bit (the 32nd in dual-line mode, the 46th in single-line mode), while cs_no is still low. Bits 15:14 of res_a_o and res_b_o repeat bit 13 (two's complement sign extension).
- R8: start_i is ignored while busy_o is high. After cs_no rises it stays high for at least CS_GAP_CYC cycles. Every start accepted while idle yields exactly one result.
- R9: cal_req_i while idle drives cal_o high for exactly CAL_HI_CYC cycles. cs_no stays high during the pulse and for at least CAL_GAP_CYC cycles after it. If cal_req_i and start_i arrive together, the calibration wins and the start is dropped.
- R10: single_line_i is latched when a frame starts. A change during the frame alters neither its length nor its capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| cal_req_i | input | 1 | Request one calibration pulse |
| single_line_i | input | 1 | 1: both results on sdata_a_i; 0: one result per line |
| sdata_a_i | input | 1 | Serial data line carrying channel A (and channel B in single-line mode) |
| sdata_b_i | input | 1 | Serial data line carrying channel B in dual-line mode |
| cs_no | output | 1 | Chip select to converter, active low |
| sclk_o | output | 1 | Serial clock to converter, idles high |
| cal_o | output | 1 | Calibration pulse to converter |
| busy_o | output | 1 | High from an accepted request until idle again |
| res_valid_o | output | 1 | One-cycle strobe for res_a_o and res_b_o |
| res_a_o | output | 16 | Channel A result, sign-extended |
| res_b_o | output | 16 | Channel B result, sign-extended |

## Verification
A result is due one system clock after the 32nd rising sclk_o edge of a dual-line frame, or after the 46th rising edge of a single-line frame. The monitor counts rising edges from the fall of cs_no and compares the count at the strobe, so an early or late strobe is caught as well as a wrong value. The monitor samples on the falling system clock edge and measures every sclk_o half period. It measures the calibration pulse width and both chip-select spacings in whole cycles, each against its parameter, at the moment the edge that closes it is seen.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL,
    ST_CALGAP,
    ST_FRAME,
    ST_CSGAP
  } seq_state_e;
endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int SCLK_HALF   = 2,
  parameter int CAL_HI_CYC  = 250,
  parameter int CAL_GAP_CYC = 250,
  parameter int CS_GAP_CYC  = 2,
  parameter int DUAL_EDGES  = 33,
  parameter int SNGL_EDGES  = 47,
  parameter int EDGE_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cal_req_i,
  input  logic              single_line_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              cal_o,
  output logic              busy_o,
  output logic              smp_o,
  output logic [EDGE_W-1:0] edge_o,
  output logic              single_o
);
  localparam int M1      = (CAL_HI_CYC > CAL_GAP_CYC) ? CAL_HI_CYC : CAL_GAP_CYC;
  localparam int M2      = (CS_GAP_CYC > SCLK_HALF) ? CS_GAP_CYC : SCLK_HALF;
  localparam int TMR_MAX = (M1 > M2) ? M1 : M2;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  seq_state_e        state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [EDGE_W-1:0] edge_q;
  logic              cs_q, sclk_q, cal_q, single_q;
  logic              half_done;
  logic [EDGE_W-1:0] last_edge;

  assign half_done = (tmr_q == TMR_W'(SCLK_HALF - 1));
  assign last_edge = single_q ? EDGE_W'(SNGL_EDGES) : EDGE_W'(DUAL_EDGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      edge_q   <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      cal_q    <= 1'b0;
      single_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (cal_req_i) begin
            state_q <= ST_CAL;
            cal_q   <= 1'b1;
          end else if (start_i) begin
            state_q  <= ST_FRAME;
            cs_q     <= 1'b0;
            edge_q   <= '0;
            single_q <= single_line_i;
          end
        end
        ST_CAL: begin
          if (tmr_q == TMR_W'(CAL_HI_CYC - 1)) begin
            cal_q   <= 1'b0;
            tmr_q   <= '0;
            state_q <= ST_CALGAP;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_CALGAP: begin
          if (tmr_q == TMR_W'(CAL_GAP_CYC - 1)) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_FRAME: begin
          if (half_done) begin
            tmr_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              edge_q <= edge_q + 1'b1;
            end else if (edge_q == last_edge) begin
              cs_q    <= 1'b1;
              state_q <= ST_CSGAP;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_CSGAP: begin
          if (tmr_q == TMR_W'(CS_GAP_CYC - 1)) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // rising edge is scheduled this cycle: data has been stable a full half period
  assign smp_o    = (state_q == ST_FRAME) && half_done && !sclk_q;
  assign edge_o   = edge_q;
  assign single_o = single_q;
  assign cs_no    = cs_q;
  assign sclk_o   = sclk_q;
  assign cal_o    = cal_q;
  assign busy_o   = (state_q != ST_IDLE);

  a_r9_cal_blocks_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_q |-> cs_q);
  a_r9_cal_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_q) |=> cs_q);
  a_r2_sclk_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> sclk_q);
  a_r3_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME) |-> (edge_q <= last_edge));
  a_r8_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |=> cs_q);
  a_r10_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && $past(!cs_q)) |-> $stable(single_q));
endmodule

// File: rtl/adc_rd_lane.sv
module adc_rd_lane #(
  parameter int DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] sr_q;

  assign next_o = {sr_q[DATA_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= next_o;
  end

  assign word_o = sr_q;
endmodule

// File: rtl/adc_dual_rd.sv
module adc_dual_rd #(
  parameter int SCLK_HALF   = 2,
  parameter int CAL_HI_CYC  = 250,
  parameter int CAL_GAP_CYC = 250,
  parameter int CS_GAP_CYC  = 2,
  parameter int CONV_EDGES  = 18,
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cal_req_i,
  input  logic             single_line_i,
  input  logic             sdata_a_i,
  input  logic             sdata_b_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             cal_o,
  output logic             busy_o,
  output logic             res_valid_o,
  output logic [OUT_W-1:0] res_a_o,
  output logic [OUT_W-1:0] res_b_o
);
  localparam int A_FIRST  = CONV_EDGES + 1;
  localparam int A_LAST   = A_FIRST + DATA_W - 1;
  localparam int B_FIRST  = A_LAST + 1;
  localparam int B_LAST   = B_FIRST + DATA_W - 1;
  localparam int DUAL_END = B_FIRST;
  localparam int SNGL_END = B_LAST + 1;
  localparam int EDGE_W   = $clog2(SNGL_END + 1);
  localparam int EXT_W    = OUT_W - DATA_W;
  localparam int LANES    = 2;

  logic              smp, single;
  logic [EDGE_W-1:0] edge_n;
  logic              win_a, win_b, last_bit;

  adc_rd_seq #(
    .SCLK_HALF  (SCLK_HALF),
    .CAL_HI_CYC (CAL_HI_CYC),
    .CAL_GAP_CYC(CAL_GAP_CYC),
    .CS_GAP_CYC (CS_GAP_CYC),
    .DUAL_EDGES (DUAL_END),
    .SNGL_EDGES (SNGL_END),
    .EDGE_W     (EDGE_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cal_req_i    (cal_req_i),
    .single_line_i(single_line_i),
    .cs_no        (cs_no),
    .sclk_o       (sclk_o),
    .cal_o        (cal_o),
    .busy_o       (busy_o),
    .smp_o        (smp),
    .edge_o       (edge_n),
    .single_o     (single)
  );

  assign win_a    = smp && (edge_n >= EDGE_W'(A_FIRST)) && (edge_n <= EDGE_W'(A_LAST));
  assign win_b    = smp && (edge_n >= EDGE_W'(B_FIRST)) && (edge_n <= EDGE_W'(B_LAST));
  assign last_bit = smp && (edge_n == (single ? EDGE_W'(B_LAST) : EDGE_W'(A_LAST)));

  logic [LANES-1:0]             lane_en, lane_bit;
  logic [LANES-1:0][DATA_W-1:0] lane_word, lane_next, lane_val;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign lane_en[g]  = win_a;
      assign lane_bit[g] = sdata_a_i;
    end else begin : g_second
      // single-line: second word trails the first on line A
      assign lane_en[g]  = single ? win_b : win_a;
      assign lane_bit[g] = single ? sdata_a_i : sdata_b_i;
    end

    adc_rd_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(lane_en[g]),
      .bit_i  (lane_bit[g]),
      .word_o (lane_word[g]),
      .next_o (lane_next[g])
    );

    assign lane_val[g] = lane_en[g] ? lane_next[g] : lane_word[g];
  end

  logic             valid_q;
  logic [OUT_W-1:0] res_a_q, res_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_a_q <= '0;
      res_b_q <= '0;
    end else begin
      valid_q <= last_bit;
      if (last_bit) begin
        res_a_q <= {{EXT_W{lane_val[0][DATA_W-1]}}, lane_val[0]};
        res_b_q <= {{EXT_W{lane_val[1][DATA_W-1]}}, lane_val[1]};
      end
    end
  end

  assign res_valid_o = valid_q;
  assign res_a_o     = res_a_q;
  assign res_b_o     = res_b_q;

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  a_r7_valid_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !cs_no);
  a_r7_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_a_o[OUT_W-1] == res_a_o[DATA_W-1]) && (res_b_o[OUT_W-1] == res_b_o[DATA_W-1]));
endmodule

// File: tb/adc_dual_rd_test.sv
`timescale 1ns/1ps
module adc_dual_rd_test;
  localparam int HALF   = 2;
  localparam int CAL_HI = 250;
  localparam int CAL_GP = 250;
  localparam int CS_GP  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, cal_req_i = 1'b0, single_line_i = 1'b0;
  logic sda = 1'b0, sdb = 1'b0;
  logic cs_no, sclk_o, cal_o, busy_o, res_valid_o;
  logic [15:0] res_a_o, res_b_o;

  always #4 clk = ~clk;

  adc_dual_rd #(
    .SCLK_HALF(HALF), .CAL_HI_CYC(CAL_HI), .CAL_GAP_CYC(CAL_GP), .CS_GAP_CYC(CS_GP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cal_req_i(cal_req_i),
    .single_line_i(single_line_i), .sdata_a_i(sda), .sdata_b_i(sdb),
    .cs_no(cs_no), .sclk_o(sclk_o), .cal_o(cal_o), .busy_o(busy_o),
    .res_valid_o(res_valid_o), .res_a_o(res_a_o), .res_b_o(res_b_o)
  );

  // converter model: bits change on falling sclk
  logic [13:0] mdl_a = '0, mdl_b = '0;
  int k = 0;
  int nk;
  always @(negedge sclk_o or posedge cs_no) begin
    if (cs_no) begin
      k <= 0; sda <= 1'b0; sdb <= 1'b0;
    end else begin
      nk = k + 1;
      k <= nk;
      if (nk < 19) begin
        sda <= nk[0]; sdb <= ~nk[0];           // junk during conversion
      end else if (nk <= 32) begin
        sda <= mdl_a[32-nk]; sdb <= mdl_b[32-nk];
      end else if (nk <= 46) begin
        sda <= mdl_b[46-nk]; sdb <= nk[0];     // line B junk in single mode
      end else begin
        sda <= 1'b0; sdb <= 1'b0;
      end
    end
  end

  typedef struct packed {
    logic        single;
    logic [15:0] a;
    logic [15:0] b;
  } exp_t;
  exp_t q[$];

  int m_chk = 0, m_fail = 0, d_chk = 0, d_fail = 0, n_valid = 0, n_push = 0;
  bit wd_fail = 1'b0, done = 1'b0;

  function automatic logic [15:0] sext(input logic [13:0] v);
    return {{2{v[13]}}, v};
  endfunction

  // monitor / scoreboard
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_cal = 1'b0, prev_valid = 1'b0;
  int hp = 0, falls = 0, rises = 0, cs_high = 0, cal_len = 0, since_cal = 0;
  bit seen_end = 1'b0, cal_pending = 1'b0, cur_single = 1'b0;
  exp_t e;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!prev_cs) begin
        if (prev_sclk != sclk_o) begin
          m_chk++;
          if (hp != HALF) begin
            m_fail++; $display("FAIL R2 half period act=%0d exp=%0d", hp, HALF);
          end
          hp = 1;
          if (!sclk_o) falls++; else rises++;
        end else hp++;
      end
      if (prev_cs && !cs_no) begin
        falls = 0; rises = 0; hp = 1;
        if (seen_end) begin
          m_chk++;
          if (cs_high < CS_GP) begin
            m_fail++; $display("FAIL R8 cs high gap act=%0d exp>=%0d", cs_high, CS_GP);
          end
        end
        if (cal_pending) begin
          m_chk++;
          if (since_cal < CAL_GP) begin
            m_fail++; $display("FAIL R9 cal to cs gap act=%0d exp>=%0d", since_cal, CAL_GP);
          end
          cal_pending = 1'b0;
        end
      end
      if (!prev_cs && cs_no) begin
        m_chk++;
        if (falls != (cur_single ? 47 : 33)) begin
          m_fail++; $display("FAIL R3 falling edges act=%0d exp=%0d", falls, cur_single ? 47 : 33);
        end
        m_chk++;
        if (sclk_o !== 1'b1) begin
          m_fail++; $display("FAIL R2 sclk at cs rise act=%b exp=1", sclk_o);
        end
        cs_high = 1; seen_end = 1'b1;
      end else if (cs_no) cs_high++;
      if (cal_o) cal_len++;
      if (prev_cal && !cal_o) begin
        m_chk++;
        if (cal_len != CAL_HI) begin
          m_fail++; $display("FAIL R9 cal width act=%0d exp=%0d", cal_len, CAL_HI);
        end
        cal_len = 0; cal_pending = 1'b1; since_cal = 1;
      end else since_cal++;
      if (res_valid_o) begin
        n_valid++;
        m_chk++;
        if (prev_valid) begin
          m_fail++; $display("FAIL R7 valid width act=2+ exp=1");
        end
        if (q.size() == 0) begin
          m_chk++; m_fail++; $display("FAIL R8 unexpected result act=%h/%h exp=none", res_a_o, res_b_o);
        end else begin
          e = q.pop_front();
          cur_single = e.single;
          m_chk++;
          if (res_a_o !== e.a) begin
            m_fail++; $display("FAIL R4 channel A act=%h exp=%h", res_a_o, e.a);
          end
          m_chk++;
          if (res_b_o !== e.b) begin
            m_fail++; $display("FAIL %s channel B act=%h exp=%h", e.single ? "R6" : "R5", res_b_o, e.b);
          end
          m_chk++;
          if (rises != (e.single ? 46 : 32) || cs_no) begin
            m_fail++; $display("FAIL R7 strobe timing act=%0d rises cs=%b exp=%0d cs=0",
                               rises, cs_no, e.single ? 46 : 32);
          end
        end
      end
      prev_cs = cs_no; prev_sclk = sclk_o; prev_cal = cal_o; prev_valid = res_valid_o;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==",
               m_chk + d_chk + (wd_fail ? 1 : 0), m_fail + d_fail + (wd_fail ? 1 : 0));
      $finish;
    end
  endtask

  task automatic dchk(input bit ok, input string tag, input int act, input int exp);
    d_chk++;
    if (!ok) begin
      d_fail++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic frame(input logic [13:0] a, input logic [13:0] b, input bit single,
                       input bit flip, input bit restart);
    exp_t x;
    mdl_a = a; mdl_b = b;
    x.single = single; x.a = sext(a); x.b = sext(b);
    q.push_back(x); n_push++;
    single_line_i = single;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (flip || restart) begin
      repeat (30) @(negedge clk);
      if (flip) single_line_i = ~single;          // R10
      if (restart) begin                          // R8
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
      end
    end
    wait_idle();
    single_line_i = single;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    dchk(cs_no == 1'b1, "R1 cs_no idle", cs_no, 1);
    dchk(sclk_o == 1'b1, "R1 sclk_o idle", sclk_o, 1);
    dchk(cal_o == 1'b0, "R1 cal_o idle", cal_o, 0);
    dchk(busy_o == 1'b0, "R1 busy_o idle", busy_o, 0);
    dchk(res_valid_o == 1'b0, "R1 valid idle", res_valid_o, 0);

    frame(14'h1234, 14'h0ABC, 1'b0, 1'b0, 1'b0);
    frame(14'h2000, 14'h3FFF, 1'b0, 1'b0, 1'b0);   // R7 negative extremes
    frame(14'h1FFF, 14'h0000, 1'b0, 1'b0, 1'b0);
    frame(14'h2AAA, 14'h1555, 1'b1, 1'b0, 1'b0);   // R6
    frame(14'h0001, 14'h3001, 1'b1, 1'b0, 1'b0);

    // R9: calibration, then a frame
    @(negedge clk) cal_req_i = 1'b1;
    @(negedge clk) cal_req_i = 1'b0;
    wait_idle();
    frame(14'h0F0F, 14'h30F0, 1'b0, 1'b0, 1'b0);

    // R9 priority: both requests in the same cycle
    @(negedge clk) begin cal_req_i = 1'b1; start_i = 1'b1; end
    @(negedge clk) begin cal_req_i = 1'b0; start_i = 1'b0; end
    dchk(cal_o == 1'b1, "R9 cal wins", cal_o, 1);
    dchk(cs_no == 1'b1, "R9 start dropped", cs_no, 1);
    wait_idle();
    frame(14'h3333, 14'h0CCC, 1'b1, 1'b0, 1'b0);

    frame(14'h1111, 14'h2222, 1'b0, 1'b1, 1'b1);   // R10 and R8 mid-frame
    frame(14'h2468, 14'h1357, 1'b1, 1'b1, 1'b1);

    repeat (10) @(negedge clk);
    dchk(n_valid == n_push, "R8 one result per start", n_valid, n_push);
    dchk(q.size() == 0, "R8 no result missing", q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end
endmodule